// File: doc/BRIEF.md
# Per-Channel Control Command Parser

This block sits on a byte-serial command port and decodes one kind of command: a variable-length update of the control settings of up to sixteen half channels. A frame is bracketed by a frame-enable input. The first byte is a tag that also carries a two-bit device address, and it must match the address strap. The second byte names the first half channel to update. After that, each half channel takes a pair of bytes: a high byte with no content, then a low byte that holds its four control bits. The channel index steps forward after every low byte, so one frame can reconfigure a run of consecutive channels.

Each half channel stores four bits: codec reset, codec bypass, companding law (u-law or A-law) and idle. These bits drive the output substitution stage. The time-slot logic presents the index of the active slot together with the codec's encoder and decoder bytes. The block replaces those bytes with fixed codes while the slot's channel is held in reset. While the channel is idle, it drops the output enable for that slot. A one-cycle write strobe and the written index are brought out so that each update can be seen.

Top module: `chan_cfg_parser`

## Requirements
- R1: After synchronous reset, every channel reads codec reset = 1, bypass = 0, law = 0 (u-law) and idle = 0, and the write strobe is low.
- R2: The first accepted byte of a frame starts a command only if bits 7:2 equal 001100 and bits 1:0 equal the `chip_id` strap. Any other first byte makes the block ignore every remaining byte of that frame, and no channel changes.
- R3: The second accepted byte is the starting channel index. A value of 0 selects channel 0, and a value of k selects channel k.
- R4: The channel bytes come in pairs, high byte first and then low byte. The high byte is ignored. In the low byte, bit 4 is codec reset, bit 3 is bypass, bit 2 is law (1 = A-law) and bit 0 is idle. Bits 7:5 and bit 1 are ignored.
- R5: The channel index increases by one after each low byte. Low bytes that arrive after channel 15 has been written, or in a frame whose starting index is 16 or more, write nothing.
- R6: A byte is accepted only on a clock where `byte_vld` and `frame_en` are both high. A clock with `frame_en` low returns the parser to the header state. A high byte with no following low byte in the same frame writes nothing.
- R7: On the clock after a low byte is accepted, `wr_stb` is high for one cycle and `wr_idx` gives the channel. The channel's settings change on the clock after that.
- R8: When the channel of `slot_idx` has codec reset = 1, `enc_out` is 0xFF. Otherwise it equals `enc_in`.
- R9: When the channel of `slot_idx` has codec reset = 1, `dec_out` is 0xFF under u-law and 0xD5 under A-law. Otherwise it equals `dec_in`.
- R10: `out_en` is low while the channel of `slot_idx` has idle = 1, and high otherwise.
- R11: A channel's settings change only through a write to that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_en | input | 1 | High for the duration of a command frame |
| byte_vld | input | 1 | Byte strobe for `byte_data` |
| byte_data | input | 8 | Command byte |
| chip_id | input | 2 | Device address strap |
| slot_idx | input | 4 | Channel owning the current time slot |
| enc_in | input | 8 | Encoder byte from the codec for the current slot |
| dec_in | input | 8 | Decoder byte from the codec for the current slot |
| cfg_rst | output | 16 | Codec reset bit per channel |
| cfg_byp | output | 16 | Codec bypass bit per channel |
| cfg_law | output | 16 | Law select per channel (1 = A-law) |
| cfg_idle | output | 16 | Idle bit per channel |
| wr_stb | output | 1 | One-cycle pulse per channel update |
| wr_idx | output | 4 | Channel being updated while `wr_stb` is high |
| enc_out | output | 8 | Encoder byte after substitution |
| dec_out | output | 8 | Decoder byte after substitution |
| out_en | output | 1 | Output enable for the current slot |

## Verification
The assertions check the timing-level invariants on every cycle. A low `frame_en` always returns the parser to its header state. A strobe only follows an accepted low byte and never follows a rejected header. A strobe lands exactly the strobed settings in the strobed channel, and a channel holds its settings on every cycle without a strobe. The substituted outputs follow the reset and idle bits of the current slot. Whether the right bytes reach the right channel can only be shown by the bench's scenarios, which replay whole frames against a model and compare all channels afterwards. Those scenarios cover the start offset, auto-increment, the clamp at the last channel, header rejection, the ignored reserved bits and split frames.

// File: rtl/chcfg_pkg.sv
// Shared types and constants for the per-channel control parser.
package chcfg_pkg;

    // Parser states: header, start index, high byte, low byte, discard.
    typedef enum logic [2:0] {
        PS_HDR,
        PS_START,
        PS_HI,
        PS_LO,
        PS_DROP
    } pstate_e;

    // Stored control bits of one half channel.
    typedef struct packed {
        logic rst;
        logic byp;
        logic law;
        logic idle;
    } chcfg_t;

    localparam logic [5:0] HDR_TAG    = 6'b001100;
    localparam logic [7:0] ENC_HOLD   = 8'hFF;
    localparam logic [7:0] DEC_HOLD_U = 8'hFF;
    localparam logic [7:0] DEC_HOLD_A = 8'hD5;

    localparam chcfg_t CFG_DEFAULT = '{rst: 1'b1, byp: 1'b0, law: 1'b0, idle: 1'b0};

    // Pull the four control fields out of a low byte; other bits are dropped.
    function automatic chcfg_t lo_fields(input logic [7:0] b);
        chcfg_t c;
        c.rst  = b[4];
        c.byp  = b[3];
        c.law  = b[2];
        c.idle = b[0];
        return c;
    endfunction

endpackage

// File: rtl/chcfg_fsm.sv
// Command byte parser.
// Checks the header tag and address, loads the start index, then walks
// high/low byte pairs and emits one registered write per low byte.
// Assumes frames are separated by at least one clock with frame_en low.
module chcfg_fsm
    import chcfg_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int IDXW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_en,
    input  logic            byte_vld,
    input  logic [7:0]      byte_data,
    input  logic [1:0]      chip_id,
    output logic            wr_stb,
    output logic [IDXW-1:0] wr_idx,
    output chcfg_t          wr_cfg
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NCH - 1);

    pstate_e         state;
    logic [IDXW-1:0] cnt;
    logic            full;
    logic            take;
    logic            hdr_ok;

    // Byte acceptance and header match.
    always_comb begin
        take   = frame_en && byte_vld;
        hdr_ok = (byte_data[7:2] == HDR_TAG) && (byte_data[1:0] == chip_id);
    end

    // State, channel counter and write register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PS_HDR;
            cnt    <= '0;
            full   <= 1'b0;
            wr_stb <= 1'b0;
            wr_idx <= '0;
            wr_cfg <= CFG_DEFAULT;
        end else begin
            wr_stb <= 1'b0;
            if (!frame_en) begin
                state <= PS_HDR;
            end else if (take) begin
                case (state)
                    PS_HDR: state <= hdr_ok ? PS_START : PS_DROP;
                    PS_START: begin
                        cnt   <= byte_data[IDXW-1:0];
                        full  <= (int'(byte_data) >= NCH);
                        state <= PS_HI;
                    end
                    PS_HI: state <= PS_LO;
                    PS_LO: begin
                        if (!full) begin
                            wr_stb <= 1'b1;
                            wr_idx <= cnt;
                            wr_cfg <= lo_fields(byte_data);
                            if (cnt == LAST_IDX) full <= 1'b1;
                            else                 cnt  <= cnt + 1'b1;
                        end
                        state <= PS_HI;
                    end
                    default: state <= PS_DROP;
                endcase
            end
        end
    end

    // R6
    frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_en |=> state == PS_HDR);

    // R2
    drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == PS_DROP |=> !wr_stb);

    // R7
    stb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(frame_en && byte_vld && state == PS_LO));

    // R7
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

endmodule

// File: rtl/chcfg_regs.sv
// Per-channel control register bank.
// One four-bit register per half channel, written from the parser's
// strobe one clock after it, and reset to the power-on defaults.
module chcfg_regs
    import chcfg_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int IDXW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic [IDXW-1:0] wr_idx,
    input  chcfg_t          wr_cfg,
    output logic [NCH-1:0]  cfg_rst,
    output logic [NCH-1:0]  cfg_byp,
    output logic [NCH-1:0]  cfg_law,
    output logic [NCH-1:0]  cfg_idle
);

    chcfg_t [NCH-1:0] cfg_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Load channel g on a strobe addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  cfg_q[g] <= CFG_DEFAULT;
            else if (wr_stb && wr_idx == IDXW'(g))       cfg_q[g] <= wr_cfg;
        end

        // Fan the fields out to the per-bit vectors.
        always_comb begin
            cfg_rst[g]  = cfg_q[g].rst;
            cfg_byp[g]  = cfg_q[g].byp;
            cfg_law[g]  = cfg_q[g].law;
            cfg_idle[g] = cfg_q[g].idle;
        end
    end

    // R7
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> cfg_q[$past(wr_idx)] == $past(wr_cfg));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(cfg_q));

endmodule

// File: rtl/chcfg_subst.sv
// Output substitution for the active time slot.
// Replaces codec bytes with fixed codes while the slot's channel is in
// reset and drops the output enable while it is idle. Purely combinational;
// assumes slot_idx is stable for the slot.
module chcfg_subst
    import chcfg_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int IDXW = $clog2(NCH)
) (
    input  logic [IDXW-1:0] slot_idx,
    input  logic [NCH-1:0]  cfg_rst,
    input  logic [NCH-1:0]  cfg_law,
    input  logic [NCH-1:0]  cfg_idle,
    input  logic [7:0]      enc_in,
    input  logic [7:0]      dec_in,
    output logic [7:0]      enc_out,
    output logic [7:0]      dec_out,
    output logic            out_en
);

    logic in_rng;
    logic s_rst;
    logic s_law;
    logic s_idle;

    // Select the active slot's control bits.
    always_comb begin
        in_rng = int'(slot_idx) < NCH;
        s_rst  = in_rng && cfg_rst[slot_idx];
        s_law  = in_rng && cfg_law[slot_idx];
        s_idle = in_rng && cfg_idle[slot_idx];
    end

    // Substitute the bytes and form the enable.
    always_comb begin
        enc_out = s_rst ? ENC_HOLD : enc_in;
        dec_out = s_rst ? (s_law ? DEC_HOLD_A : DEC_HOLD_U) : dec_in;
        out_en  = !s_idle;
    end

endmodule

// File: rtl/chan_cfg_parser.sv
// Per-channel control command parser, top level.
// Joins the byte parser, the register bank and the slot substitution.
// Assumes one command frame per frame_en window and a slot index from
// the surrounding time-slot logic.
module chan_cfg_parser
    import chcfg_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int IDXW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_en,
    input  logic            byte_vld,
    input  logic [7:0]      byte_data,
    input  logic [1:0]      chip_id,
    input  logic [IDXW-1:0] slot_idx,
    input  logic [7:0]      enc_in,
    input  logic [7:0]      dec_in,
    output logic [NCH-1:0]  cfg_rst,
    output logic [NCH-1:0]  cfg_byp,
    output logic [NCH-1:0]  cfg_law,
    output logic [NCH-1:0]  cfg_idle,
    output logic            wr_stb,
    output logic [IDXW-1:0] wr_idx,
    output logic [7:0]      enc_out,
    output logic [7:0]      dec_out,
    output logic            out_en
);

    chcfg_t wr_cfg;

    chcfg_fsm #(.NCH(NCH), .IDXW(IDXW)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_en  (frame_en),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .chip_id   (chip_id),
        .wr_stb    (wr_stb),
        .wr_idx    (wr_idx),
        .wr_cfg    (wr_cfg)
    );

    chcfg_regs #(.NCH(NCH), .IDXW(IDXW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_idx   (wr_idx),
        .wr_cfg   (wr_cfg),
        .cfg_rst  (cfg_rst),
        .cfg_byp  (cfg_byp),
        .cfg_law  (cfg_law),
        .cfg_idle (cfg_idle)
    );

    chcfg_subst #(.NCH(NCH), .IDXW(IDXW)) i_subst (
        .slot_idx (slot_idx),
        .cfg_rst  (cfg_rst),
        .cfg_law  (cfg_law),
        .cfg_idle (cfg_idle),
        .enc_in   (enc_in),
        .dec_in   (dec_in),
        .enc_out  (enc_out),
        .dec_out  (dec_out),
        .out_en   (out_en)
    );

    // R8
    enc_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst[slot_idx] |-> enc_out == ENC_HOLD);

    // R9
    dec_alaw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rst[slot_idx] && cfg_law[slot_idx]) |-> dec_out == DEC_HOLD_A);

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_idle[slot_idx] |-> !out_en);

endmodule

// File: tb/test_chan_cfg_parser.sv
// Directed bench for chan_cfg_parser; one task per scenario.
module test_chan_cfg_parser;

    localparam int NCH  = 16;
    localparam int IDXW = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            frame_en;
    logic            byte_vld;
    logic [7:0]      byte_data;
    logic [1:0]      chip_id;
    logic [IDXW-1:0] slot_idx;
    logic [7:0]      enc_in;
    logic [7:0]      dec_in;
    logic [NCH-1:0]  cfg_rst, cfg_byp, cfg_law, cfg_idle;
    logic            wr_stb;
    logic [IDXW-1:0] wr_idx;
    logic [7:0]      enc_out, dec_out;
    logic            out_en;

    logic [NCH-1:0]  m_rst, m_byp, m_law, m_idle;
    int              n_chk = 0;
    int              n_err = 0;
    bit              finished = 1'b0;

    always #2 clk = ~clk;

    chan_cfg_parser #(.NCH(NCH), .IDXW(IDXW)) i_chan_cfg_parser (
        .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .byte_vld(byte_vld),
        .byte_data(byte_data), .chip_id(chip_id), .slot_idx(slot_idx),
        .enc_in(enc_in), .dec_in(dec_in), .cfg_rst(cfg_rst), .cfg_byp(cfg_byp),
        .cfg_law(cfg_law), .cfg_idle(cfg_idle), .wr_stb(wr_stb), .wr_idx(wr_idx),
        .enc_out(enc_out), .dec_out(dec_out), .out_en(out_en)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_model(input string req);
        chk(req, "cfg_rst",  cfg_rst,  m_rst);
        chk(req, "cfg_byp",  cfg_byp,  m_byp);
        chk(req, "cfg_law",  cfg_law,  m_law);
        chk(req, "cfg_idle", cfg_idle, m_idle);
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        frame_en  = 1'b1;
        byte_vld  = 1'b1;
        byte_data = b;
    endtask

    task automatic close_frame();
        @(negedge clk);
        byte_vld  = 1'b0;
        byte_data = 8'h00;
        frame_en  = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic model_write(input int ch, input logic [7:0] lo);
        m_rst[ch]  = lo[4];
        m_byp[ch]  = lo[3];
        m_law[ch]  = lo[2];
        m_idle[ch] = lo[0];
    endtask

    // Full frame with generated low bytes (reserved bits included).
    task automatic send_frame(input logic [7:0] hdr, input int start,
                              input int n, input int seed);
        bit ok;
        ok = (hdr[7:2] == 6'b001100) && (hdr[1:0] == chip_id);
        put_byte(hdr);
        put_byte(8'(start));
        for (int i = 0; i < n; i++) begin
            logic [7:0] lo;
            lo = 8'((seed * 29 + i * 53) ^ (i * 7 + 8'hA0));
            put_byte(8'h00);
            put_byte(lo);
            if (ok && start + i < NCH) model_write(start + i, lo);
        end
        close_frame();
    endtask

    task automatic write_one(input logic [7:0] hdr, input int ch, input logic [7:0] lo);
        put_byte(hdr);
        put_byte(8'(ch));
        put_byte(8'h00);
        put_byte(lo);
        close_frame();
        model_write(ch, lo);
    endtask

    task automatic t_reset();
        check_model("R1");
        chk("R1", "wr_stb", wr_stb, 0);
        slot_idx = 4'd0; enc_in = 8'h12; dec_in = 8'h34;
        #1;
        chk("R8", "enc_out after reset", enc_out, 8'hFF);
        chk("R9", "dec_out after reset", dec_out, 8'hFF);
        chk("R10", "out_en after reset", out_en, 1);
    endtask

    task automatic t_timing();
        put_byte(8'h32);
        put_byte(8'h06);
        put_byte(8'h00);
        put_byte(8'h0D);
        @(negedge clk);
        byte_vld = 1'b0;
        chk("R7", "wr_stb after low byte", wr_stb, 1);
        chk("R7", "wr_idx", wr_idx, 6);
        chk("R7", "cfg_byp[6] not yet", cfg_byp[6], 0);
        @(negedge clk);
        chk("R7", "wr_stb one cycle", wr_stb, 0);
        chk("R7", "cfg_byp[6] updated", cfg_byp[6], 1);
        frame_en = 1'b0;
        @(negedge clk);
        model_write(6, 8'h0D);
        check_model("R7");
    endtask

    task automatic t_multi();
        send_frame(8'h32, 3, 5, 11);
        check_model("R3");
        send_frame(8'h32, 0, 2, 5);
        check_model("R4");
    endtask

    task automatic t_reject();
        send_frame(8'h31, 0, 4, 3);
        check_model("R2");
        send_frame(8'h72, 0, 4, 4);
        check_model("R2");
        send_frame(8'h36, 0, 4, 6);
        check_model("R2");
    endtask

    task automatic t_wrap();
        send_frame(8'h32, 13, 5, 9);
        check_model("R5");
        send_frame(8'h32, 20, 3, 2);
        check_model("R5");
    endtask

    task automatic t_split();
        put_byte(8'h32);
        put_byte(8'h09);
        put_byte(8'h00);
        close_frame();
        check_model("R6");
        put_byte(8'h32);
        put_byte(8'h02);
        put_byte(8'h00);
        @(negedge clk);
        byte_vld  = 1'b0;
        byte_data = 8'hFF;
        @(negedge clk);
        put_byte(8'h08);
        close_frame();
        model_write(2, 8'h08);
        check_model("R6");
    endtask

    task automatic t_subst();
        chip_id = 2'b01;
        write_one(8'h31, 0, 8'h10);
        write_one(8'h31, 1, 8'h14);
        write_one(8'h31, 2, 8'h00);
        write_one(8'h31, 3, 8'h01);
        check_model("R11");
        enc_in = 8'h3C; dec_in = 8'h5A;
        slot_idx = 4'd0; #1;
        chk("R8", "enc_out ch0", enc_out, 8'hFF);
        chk("R9", "dec_out ch0 u-law", dec_out, 8'hFF);
        slot_idx = 4'd1; #1;
        chk("R9", "dec_out ch1 A-law", dec_out, 8'hD5);
        slot_idx = 4'd2; #1;
        chk("R8", "enc_out ch2 pass", enc_out, 8'h3C);
        chk("R9", "dec_out ch2 pass", dec_out, 8'h5A);
        chk("R10", "out_en ch2", out_en, 1);
        slot_idx = 4'd3; #1;
        chk("R10", "out_en ch3 idle", out_en, 0);
        write_one(8'h31, 3, 8'h00);
        #1;
        chk("R10", "out_en ch3 restored", out_en, 1);
    endtask

    initial begin
        rst_n = 1'b0; frame_en = 1'b0; byte_vld = 1'b0; byte_data = 8'h00;
        chip_id = 2'b10; slot_idx = '0; enc_in = '0; dec_in = '0;
        m_rst = '1; m_byp = '0; m_law = '0; m_idle = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_multi();
        t_reject();
        t_wrap();
        t_split();
        t_subst();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule